// File: doc/BRIEF.md
# Seconds/Minutes Watchdog Timer

This block is a watchdog timer. Software reaches it through a small window of byte registers: a control register, a configuration register, and a low and a high count register. The count is loaded as one value. A write to the low count register takes the pending high byte with it, starts the countdown and clears the minute divider. Writing the count again before it runs out is the keep-alive. Writing a count of zero stops the timer.

The counter moves only on a one-second strobe that the surrounding logic supplies. In seconds mode, every strobe takes one off the count. In minutes mode, every sixtieth strobe after a reload does. When the count reaches zero the block does three things at once for a single clock: it raises a timeout flag in the control register, it pulses the system reset output if that output is enabled, and it pulses the keyboard reset output if that output is enabled. It then stays stopped until the count is written again. The counter width is a parameter of 8 or 16 bits. In the 8-bit variant there is no high count register.

Top module: `secmin_wdt`

## Requirements
- R1: After reset both reset outputs are low, the configuration register reads 0x00, the count reads zero and the timer is stopped.
- R2: The configuration register at offset 0x72 reads back all 8 bits as written. The control register at offset 0x71 reads the timeout flag in bit 0 and zero in the other bits, and writes to it have no effect. The live count reads at 0x73 (low byte) and 0x74 (high byte). Any other offset reads 0x00.
- R3: A write to 0x74 changes only the pending high byte and leaves the live count unchanged. A write to 0x73 loads {pending high byte, written byte} into the count, starts the countdown if that value is non-zero, and clears the minute divider.
- R4: With configuration bit 7 set (seconds), each strobe on `sec_tick` while the timer runs lowers the count by one.
- R5: With configuration bit 7 clear (minutes), the count drops by one on the 60th strobe after a reload and on every 60th strobe after that.
- R6: Loading a count of zero stops the timer. No timeout follows, whatever strobes arrive.
- R7: On the clock edge where the count goes from 1 to 0, the timer stops. For exactly the next cycle the control register bit 0 reads 1, and `sys_rst_o` is high if configuration bit 4 is set.
- R8: At that same expiry, `kbd_rst_o` is high for exactly one cycle if configuration bit 6 is set, and it stays low otherwise.
- R9: Strobes arriving while the timer is stopped leave the count unchanged. A load in the same cycle as a strobe wins, and the strobe is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write offset |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read offset |
| rd_data | output | 8 | Register read data, combinational |
| sys_rst_o | output | 1 | System reset pulse on timeout |
| kbd_rst_o | output | 1 | Keyboard reset pulse on timeout |

## Verification
The countdown is exercised in both units:
- In seconds mode, short loads expire after a few strobes. This separates the decrement and expiry timing from the divider.
- In minutes mode, a count of two is run through all 120 strobes. Readbacks at strobes 59 and 60 show where the divider boundary lies.

A reload in the middle of a minute shows whether the divider restarts, and a strobe that coincides with a load shows which of the two wins. Three more patterns cover the remaining behaviour:
- A zero load and strobes sent after expiry show that a stopped timer ignores the second strobe.
- A lone high-byte write shows that the live count is untouched until the low byte is written.
- Different configuration values separate the system reset output from the keyboard reset output.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Register window offsets inside the watchdog bank
  localparam logic [7:0] ADDR_CTRL = 8'h71;
  localparam logic [7:0] ADDR_CFG  = 8'h72;
  localparam logic [7:0] ADDR_LSB  = 8'h73;
  localparam logic [7:0] ADDR_MSB  = 8'h74;

  // Configuration byte, MSB first
  typedef struct packed {
    logic       sec_unit;  // 1: count seconds, 0: count minutes
    logic       kbd_en;    // pulse keyboard reset on expiry
    logic       evt_en;    // timeout event enable (stored only)
    logic       pwr_en;    // pulse system reset on expiry
    logic [3:0] irq_sel;   // interrupt select (stored only)
  } wdt_cfg_t;

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [7:0]       rd_addr,
  input  logic [CNT_W-1:0] cnt,
  input  logic             tmo,
  output wdt_cfg_t         cfg,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic [7:0]       rd_data
);

  localparam bit HAS_MSB = (CNT_W > 8);

  wdt_cfg_t   cfg_q, cfg_d;
  logic       cfg_we;
  logic [7:0] msb_view;

  assign cfg_we = wr_en && (wr_addr == ADDR_CFG);
  assign load   = wr_en && (wr_addr == ADDR_LSB);

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) cfg_d = wdt_cfg_t'(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  generate
    if (HAS_MSB) begin : g_msb
      logic [7:0] msb_q, msb_d;
      logic       msb_we;

      assign msb_we = wr_en && (wr_addr == ADDR_MSB);

      always_comb begin
        msb_d = msb_q;
        if (msb_we) msb_d = wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) msb_q <= '0;
        else        msb_q <= msb_d;
      end

      assign load_val = {msb_q[CNT_W-9:0], wr_data};
      assign msb_view = 8'(cnt[CNT_W-1:8]);
    end else begin : g_nomsb
      assign load_val = wr_data[CNT_W-1:0];
      assign msb_view = 8'h00;
    end
  endgenerate

  always_comb begin
    case (rd_addr)
      ADDR_CTRL: rd_data = {7'b0, tmo};
      ADDR_CFG:  rd_data = cfg_q;
      ADDR_LSB:  rd_data = cnt[7:0];
      ADDR_MSB:  rd_data = msb_view;
      default:   rd_data = 8'h00;
    endcase
  end

endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int TPM = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic run,
  input  logic sec_unit,
  output logic dec
);

  localparam int DIV_W = $clog2(TPM);
  localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(TPM - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic             wrap;
  logic             step_en;

  assign wrap    = (div_q == DIV_TOP);
  assign step_en = run && tick && !sec_unit;
  assign dec     = run && tick && (sec_unit || wrap);

  always_comb begin
    div_d = div_q;
    if (clr)          div_d = '0;
    else if (step_en) div_d = wrap ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  input  logic             pwr_en,
  input  logic             kbd_en,
  output logic [CNT_W-1:0] cnt,
  output logic             run,
  output logic             tmo,
  output logic             sys_rst,
  output logic             kbd_rst
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             expire;
  logic             tmo_q, sys_q, kbd_q;

  assign expire = !load && dec && (cnt_q == ONE);

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (load) begin
      cnt_d = load_val;
      run_d = (load_val != '0);
    end else if (dec) begin
      cnt_d = cnt_q - ONE;
      if (expire) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      tmo_q <= 1'b0;
      sys_q <= 1'b0;
      kbd_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      tmo_q <= expire;
      sys_q <= expire && pwr_en;
      kbd_q <= expire && kbd_en;
    end
  end

  assign cnt     = cnt_q;
  assign run     = run_q;
  assign tmo     = tmo_q;
  assign sys_rst = sys_q;
  assign kbd_rst = kbd_q;

endmodule

// File: rtl/secmin_wdt.sv
module secmin_wdt
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TPM   = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       sys_rst_o,
  output logic       kbd_rst_o
);

  wdt_cfg_t         cfg;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic             tmo;
  logic             dec;

  wdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .cnt      (cnt),
    .tmo      (tmo),
    .cfg      (cfg),
    .load     (load),
    .load_val (load_val),
    .rd_data  (rd_data)
  );

  wdt_prescale #(.TPM(TPM)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (load),
    .tick     (sec_tick),
    .run      (run),
    .sec_unit (cfg.sec_unit),
    .dec      (dec)
  );

  wdt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .dec      (dec),
    .pwr_en   (cfg.pwr_en),
    .kbd_en   (cfg.kbd_en),
    .cnt      (cnt),
    .run      (run),
    .tmo      (tmo),
    .sys_rst  (sys_rst_o),
    .kbd_rst  (kbd_rst_o)
  );

endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic [CNT_W-1:0] cnt,
  input logic             run,
  input logic             tmo,
  input logic             sys_rst_o,
  input logic             kbd_rst_o
);

  // R7
  tmo_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> !tmo);

  // R7
  sys_with_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> tmo);

  // R8
  kbd_with_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_rst_o |-> tmo);

  // R9
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt));

  // R4
  no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cnt <= $past(cnt)));

  // R6
  zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt == '0) && !load) |=> !tmo);

  // R3
  load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !tmo);

endmodule

bind secmin_wdt wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load      (load),
  .cnt       (cnt),
  .run       (run),
  .tmo       (tmo),
  .sys_rst_o (sys_rst_o),
  .kbd_rst_o (kbd_rst_o)
);

// File: tb/test_secmin_wdt.sv
module test_secmin_wdt;

  localparam int CNT_W = 16;
  localparam int TPM   = 60;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sec_tick;
  logic       wr_en;
  logic [7:0] wr_addr, wr_data, rd_addr;
  logic [7:0] rd_data;
  logic       sys_rst_o, kbd_rst_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  secmin_wdt #(.CNT_W(CNT_W), .TPM(TPM)) i_secmin_wdt (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .sys_rst_o(sys_rst_o), .kbd_rst_o(kbd_rst_o)
  );

  // Behavioural reference state
  int m_cnt, m_run, m_div, m_cfg, m_msb, m_tmo, m_sys, m_kbd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_run = 0; m_div = 0; m_cfg = 0; m_msb = 0;
      m_tmo = 0; m_sys = 0; m_kbd = 0;
    end else begin
      int old_cfg;
      bit step;
      old_cfg = m_cfg;
      m_tmo = 0; m_sys = 0; m_kbd = 0;
      step = 0;
      if (wr_en && wr_addr == 8'h72) m_cfg = wr_data;
      if (wr_en && wr_addr == 8'h74) m_msb = wr_data;
      if (wr_en && wr_addr == 8'h73) begin
        m_cnt = m_msb * 256 + wr_data;
        m_run = (m_cnt != 0);
        m_div = 0;
      end else if (m_run != 0 && sec_tick) begin
        if (old_cfg[7]) step = 1;
        else if (m_div == TPM - 1) begin step = 1; m_div = 0; end
        else m_div = m_div + 1;
        if (step) begin
          m_cnt = m_cnt - 1;
          if (m_cnt == 0) begin
            m_run = 0; m_tmo = 1;
            m_sys = old_cfg[4]; m_kbd = old_cfg[6];
          end
        end
      end
    end
  end

  function automatic int model_rd(input logic [7:0] a);
    case (a)
      8'h71: return m_tmo;
      8'h72: return m_cfg;
      8'h73: return m_cnt % 256;
      8'h74: return m_cnt / 256;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    #2;
    if (rst_n) begin
      chk("R7 sys_rst_o vs model", int'(sys_rst_o), m_sys);
      chk("R8 kbd_rst_o vs model", int'(kbd_rst_o), m_kbd);
      chk("R2 rd_data vs model", int'(rd_data), model_rd(rd_addr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
    end
  endtask

  task automatic rdchk(input logic [7:0] a, input int exp, input string req);
    @(negedge clk); rd_addr = a; #3;
    chk(req, int'(rd_data), exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual %0d expected 0", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sec_tick = 1'b0; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rdchk(8'h72, 0, "R1 cfg after reset");
    rdchk(8'h73, 0, "R1 count low after reset");
    chk("R1 sys_rst_o after reset", int'(sys_rst_o), 0);
    chk("R1 kbd_rst_o after reset", int'(kbd_rst_o), 0);

    // R2 register map
    wr(8'h72, 8'h9F);
    rdchk(8'h72, 8'h9F, "R2 cfg readback");
    wr(8'h71, 8'hFF);
    rdchk(8'h71, 0, "R2 control write ignored");
    rdchk(8'h55, 0, "R2 unmapped offset");

    // R3 pending high byte
    wr(8'h74, 8'h01);
    rdchk(8'h74, 0, "R3 high write leaves count");
    wr(8'h73, 8'h05);
    rdchk(8'h74, 1, "R3 load high byte");
    rdchk(8'h73, 5, "R3 load low byte");

    // R4 seconds mode
    wr(8'h72, 8'h90);
    tick(3);
    rdchk(8'h73, 2, "R4 three second decrements");

    // R7 expiry with system reset enabled
    wr(8'h74, 8'h00);
    wr(8'h73, 8'h03);
    tick(2);
    rd_addr = 8'h71;
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0; #3;
    chk("R7 sys_rst_o pulse", int'(sys_rst_o), 1);
    chk("R7 timeout flag", int'(rd_data), 1);
    chk("R8 kbd_rst_o disabled", int'(kbd_rst_o), 0);
    @(negedge clk); #3;
    chk("R7 pulse one cycle", int'(sys_rst_o), 0);
    chk("R7 flag one cycle", int'(rd_data), 0);

    // R9 stopped timer ignores strobes
    tick(5);
    rdchk(8'h73, 0, "R9 stopped count");

    // R5 and R8 minutes mode with keyboard reset
    wr(8'h72, 8'h40);
    wr(8'h73, 8'h02);
    tick(59);
    rdchk(8'h73, 2, "R5 before first minute");
    tick(1);
    rdchk(8'h73, 1, "R5 at first minute");
    tick(59);
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0; #3;
    chk("R8 kbd_rst_o pulse", int'(kbd_rst_o), 1);
    chk("R7 sys_rst_o disabled", int'(sys_rst_o), 0);

    // R3 reload clears the minute divider
    wr(8'h72, 8'h00);
    wr(8'h73, 8'h02);
    tick(30);
    wr(8'h73, 8'h02);
    tick(59);
    rdchk(8'h73, 2, "R3 divider cleared by reload");
    tick(1);
    rdchk(8'h73, 1, "R3 minute after reload");

    // R6 zero write stops
    wr(8'h72, 8'h90);
    wr(8'h73, 8'h05);
    tick(2);
    wr(8'h73, 8'h00);
    tick(10);
    rdchk(8'h73, 0, "R6 stopped by zero");
    chk("R6 no reset", int'(sys_rst_o), 0);

    // R9 load beats a coincident strobe
    @(negedge clk); wr_en = 1'b1; wr_addr = 8'h73; wr_data = 8'h04; sec_tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; sec_tick = 1'b0;
    rdchk(8'h73, 4, "R9 load wins over strobe");
    tick(1);
    rdchk(8'h73, 3, "R9 next strobe counts");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule